// File: doc/BRIEF.md
# Masked Interrupt Request Controller

The controller collects event pulses from eight peripheral sources into sticky identification flags. It ANDs those flags with a per-source enable mask and raises one request line toward the CPU. While the CPU services an interrupt, a single in-service bit holds off every source. The in-service bit is set when the CPU takes the request. It is cleared by a return-from-interrupt pulse, by a pop-with-clear pulse, or by a software write. Software that writes zero from inside a handler allows nesting under whatever mask value it has just programmed.

Masking gates only the request. An identification flag still records its event when its mask bit is zero, so a handler can poll sources it has chosen not to be interrupted by. Software reaches the block through a small register port. Offset 0 is the mask. Offset 1 holds the identification flags; reading returns them, and writing clears them one bit per bit set. Offset 2 is the in-service bit. Offset 3 is a read of the pending vector.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask, the identification flags and the in-service bit are all zero, and both irqReq and vecTaken are low.
- R2: A high bit of srcEvent sets the matching identification flag at the next clock edge whatever the mask holds. The flag stays set until it is cleared, and reading offset 1 returns the flags.
- R3: A write to offset 1 clears each flag whose data bit is 1. If a source event arrives in the same cycle as the clear, the flag stays set.
- R4: irqReq is high exactly when globalEn is 1, the in-service bit is 0, and at least one source has both its flag and its mask bit set. A write to offset 0 loads the mask, and reading offset 0 returns it.
- R5: If cpuAccept is high while irqReq is high, vecTaken is high for exactly the following cycle and the in-service bit is 1 from that cycle on. cpuAccept with no request produces no strobe.
- R6: While the in-service bit is 1, irqReq stays low for every source and every mask value.
- R7: A write to offset 2 loads data bit 0 into the in-service bit, which reads back at offset 2 bit 0. Writing 0 lets a pending masked-in source request again.
- R8: A retiPulse or a popClrPulse clears the in-service bit at the next edge, and either pulse overrides a software write in the same cycle.
- R9: An acceptance in the same cycle as a clear pulse or a software write of 0 leaves the in-service bit set and still produces the strobe.
- R10: A read of offset 3 returns the flags ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | 8 | Per-source event pulses |
| globalEn | input | 1 | Global interrupt enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| cpuAccept | input | 1 | CPU takes the pending request |
| retiPulse | input | 1 | Return-from-interrupt pulse |
| popClrPulse | input | 1 | Pop-with-clear pulse |
| irqReq | output | 1 | Interrupt request to the CPU |
| vecTaken | output | 1 | One-cycle vector-taken strobe |
| inService | output | 1 | In-service bit |

## Verification
The bench drives an event and a write-one-to-clear in the same cycle. A design that gives the clear priority would lose the event and read back zero. It records events with the mask at zero and then opens the mask. A design that gates the flag instead of the request would never raise irqReq afterwards. It also holds cpuAccept for several cycles and overlaps acceptance with return pulses. A strobe longer than one cycle, or a clear that beats acceptance, shows up as a mismatch on vecTaken or inService against the bench model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INS  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd3;

  typedef struct packed {
    logic wrMask;
    logic clrFlag;
  } regStrobeT;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobeT           strb,
  input  logic [NUM_SRC-1:0]  srcEvent,
  input  logic [NUM_SRC-1:0]  wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                insQ,
  output logic                anyPend,
  output logic [NUM_SRC-1:0]  rdData
);
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] pendVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
        maskQ[i] <= 1'b0;
      end else begin
        // an event in the same cycle beats a clear
        if (srcEvent[i])
          flagQ[i] <= 1'b1;
        else if (strb.clrFlag && wrData[i])
          flagQ[i] <= 1'b0;
        if (strb.wrMask)
          maskQ[i] <= wrData[i];
      end
    end
  end

  assign pendVec = flagQ & maskQ;
  assign anyPend = |pendVec;

  always_comb begin
    unique case (rdAddr)
      ADDR_MASK: rdData = maskQ;
      ADDR_FLAG: rdData = flagQ;
      ADDR_INS:  rdData = {{(NUM_SRC-1){1'b0}}, insQ};
      default:   rdData = pendVec;
    endcase
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvent) |=> ((flagQ & $past(srcEvent)) == $past(srcEvent)));

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrFlag |=> ((flagQ & $past(flagQ)) == $past(flagQ)));
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrBit0,
  input  logic              globalEn,
  input  logic              anyPend,
  input  logic              cpuAccept,
  input  logic              retiPulse,
  input  logic              popClrPulse,
  output regStrobeT         strb,
  output logic              irqReq,
  output logic              vecTaken,
  output logic              insQ
);
  logic insWr;
  logic takeNow;
  logic clrPulse;

  always_comb begin
    strb.wrMask  = regWrEn && (regAddr == ADDR_MASK);
    strb.clrFlag = regWrEn && (regAddr == ADDR_FLAG);
    insWr        = regWrEn && (regAddr == ADDR_INS);
  end

  assign irqReq   = anyPend && globalEn && !insQ;
  assign takeNow  = cpuAccept && irqReq;
  assign clrPulse = retiPulse || popClrPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      insQ     <= 1'b0;
      vecTaken <= 1'b0;
    end else begin
      vecTaken <= takeNow;
      if (takeNow)
        insQ <= 1'b1;
      else if (clrPulse)
        insQ <= 1'b0;
      else if (insWr)
        insQ <= wrBit0;
    end
  end

  // R5
  vec_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecTaken |=> !vecTaken);

  // R5
  vec_ins_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecTaken |-> insQ);

  // R8
  ret_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrPulse && !takeNow) |=> !insQ);

  // R9
  take_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeNow |=> (insQ && vecTaken));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               globalEn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic               cpuAccept,
  input  logic               retiPulse,
  input  logic               popClrPulse,
  output logic               irqReq,
  output logic               vecTaken,
  output logic               inService
);
  regStrobeT strb;
  logic      anyPend;

  irqc_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .wrBit0     (regWrData[0]),
    .globalEn   (globalEn),
    .anyPend    (anyPend),
    .cpuAccept  (cpuAccept),
    .retiPulse  (retiPulse),
    .popClrPulse(popClrPulse),
    .strb       (strb),
    .irqReq     (irqReq),
    .vecTaken   (vecTaken),
    .insQ       (inService)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcEvent(srcEvent),
    .wrData  (regWrData),
    .rdAddr  (regAddr),
    .insQ    (inService),
    .anyPend (anyPend),
    .rdData  (regRdData)
  );
endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] srcEvent;
  logic       globalEn;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       cpuAccept;
  logic       retiPulse;
  logic       popClrPulse;
  logic       irqReq;
  logic       vecTaken;
  logic       inService;

  int errors = 0;
  int checks = 0;

  logic [7:0] mFlag, mMask;
  logic       mIns, mVec;

  always #4 clk = ~clk;

  irq_mask_ctrl i_irq_mask_ctrl (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .globalEn(globalEn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .cpuAccept(cpuAccept), .retiPulse(retiPulse),
    .popClrPulse(popClrPulse), .irqReq(irqReq), .vecTaken(vecTaken),
    .inService(inService)
  );

  function automatic logic expReq();
    return (|(mFlag & mMask)) && globalEn && !mIns;
  endfunction

  function automatic logic [7:0] expRd();
    case (regAddr)
      2'd0:    return mMask;
      2'd1:    return mFlag;
      2'd2:    return {7'd0, mIns};
      default: return mFlag & mMask;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    string rdTag;
    case (regAddr)
      2'd1: rdTag = "R2";
      2'd2: rdTag = "R7";
      2'd3: rdTag = "R10";
      default: rdTag = "R4";
    endcase
    chk(rdTag, regRdData, expRd());
    chk(mIns ? "R6" : "R4", {7'd0, irqReq}, {7'd0, expReq()});
    chk("R5", {7'd0, vecTaken}, {7'd0, mVec});
    chk("R8", {7'd0, inService}, {7'd0, mIns});
  endtask

  task automatic tick();
    logic take, nIns;
    logic [7:0] nFlag, nMask, clrBits;
    @(posedge clk);
    take    = cpuAccept && expReq();
    clrBits = (regWrEn && regAddr == 2'd1) ? regWrData : 8'd0;
    nFlag   = (mFlag & ~clrBits) | srcEvent;
    nMask   = (regWrEn && regAddr == 2'd0) ? regWrData : mMask;
    if (take) nIns = 1'b1;
    else if (retiPulse || popClrPulse) nIns = 1'b0;
    else if (regWrEn && regAddr == 2'd2) nIns = regWrData[0];
    else nIns = mIns;
    mFlag = nFlag; mMask = nMask; mIns = nIns; mVec = take;
    @(negedge clk);
    checkAll();
  endtask

  task automatic idle();
    srcEvent = 0; regWrEn = 0; regWrData = 0;
    cpuAccept = 0; retiPulse = 0; popClrPulse = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); globalEn = 0; regAddr = 0; rstN = 0;
    mFlag = 0; mMask = 0; mIns = 0; mVec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", regRdData, 8'h00);
    chk("R1", {6'd0, irqReq, vecTaken}, 8'h00);
    chk("R1", {7'd0, inService}, 8'h00);
    regAddr = 2'd1; #1;
    chk("R1", regRdData, 8'h00);
    rstN = 1;

    // R2 flag sets with mask zero, no request
    srcEvent = 8'h05; tick(); idle();
    chk("R2", regRdData, 8'h05);
    chk("R2", {7'd0, irqReq}, 8'h00);
    tick();
    chk("R2", regRdData, 8'h05);

    // R3 clear with a simultaneous event on bit 0
    regWrEn = 1; regWrData = 8'h05; srcEvent = 8'h01; tick(); idle();
    chk("R3", regRdData, 8'h01);

    // R4 open the mask, toggle the global enable
    regAddr = 2'd0; regWrEn = 1; regWrData = 8'h01; globalEn = 1; tick(); idle();
    chk("R4", {7'd0, irqReq}, 8'h01);
    globalEn = 0; #1;
    chk("R4", {7'd0, irqReq}, 8'h00);
    globalEn = 1;

    // R5 accept held for two cycles
    cpuAccept = 1; tick();
    chk("R5", {6'd0, vecTaken, inService}, 8'h03);
    tick(); idle();
    chk("R5", {7'd0, vecTaken}, 8'h00);
    chk("R6", {7'd0, irqReq}, 8'h00);

    // R7 software re-enable allows nesting
    regAddr = 2'd2; regWrEn = 1; regWrData = 8'h00; tick(); idle();
    chk("R7", {6'd0, inService, irqReq}, 8'h01);

    // R8 return and pop-with-clear
    cpuAccept = 1; tick(); idle();
    retiPulse = 1; tick(); idle();
    chk("R8", {7'd0, inService}, 8'h00);
    cpuAccept = 1; tick(); idle();
    popClrPulse = 1; regWrEn = 1; regWrData = 8'h01; tick(); idle();
    chk("R8", {7'd0, inService}, 8'h00);

    // R9 acceptance beats a return pulse in the same cycle
    cpuAccept = 1; retiPulse = 1; tick(); idle();
    chk("R9", {6'd0, vecTaken, inService}, 8'h03);
    retiPulse = 1; tick(); idle();

    // R10 pending view
    regAddr = 2'd3; srcEvent = 8'h82; tick(); idle();
    chk("R10", regRdData, 8'h01);

    for (int n = 0; n < 4000; n++) begin
      srcEvent    = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      regWrEn     = ($urandom % 5 == 0);
      regAddr     = 2'($urandom);
      regWrData   = 8'($urandom);
      globalEn    = ($urandom % 8 != 0);
      cpuAccept   = ($urandom % 2 == 0);
      retiPulse   = ($urandom % 6 == 0);
      popClrPulse = ($urandom % 9 == 0);
      #1;
      chk("R4", {7'd0, irqReq}, {7'd0, expReq()});
      tick();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule